// File: doc/BRIEF.md
# Latchable Parity Transceiver

This block moves an 8-bit data word and its parity bit between two ports, A and B, in either direction. Each port has its own transparent latch on the nine bits that come in on it. A latch passes its input straight through while its enable is high. When the enable goes low, the latch keeps the word it last captured. Parity for the outgoing bus can come from two places. In one mode the block regenerates it from the data. In the other mode it forwards the incoming parity bit unchanged.

Each port has its own parity checker. Both checkers run at all times, and each drives an active-low error flag. On the side that is driving, the latch takes in the word the block is putting out. While that latch is transparent, its checker therefore watches the outgoing word, so both flags are live at the same time. A surrounding tri-state pad is expected to build each bus from the separate in, out and enable signals.

Top module: `ptx_transceiver`

## Requirements
- R1: When `a_drv_n` and `b_drv_n` are both high, or both low, neither side is driven: `a_oe` and `b_oe` are 0 and every data and parity output is 0.
- R2: `b_drv_n` low with `a_drv_n` high drives B from the A latch (`b_oe`=1). `a_drv_n` low with `b_drv_n` high drives A from the B latch (`a_oe`=1). The two enables `a_oe` and `b_oe` are never 1 together.
- R3: While a latch enable (`a_le`, `b_le`) is high, the latch output equals its input in the same cycle.
- R4: While a latch enable is low, the latch holds the value it had at the last rising clock edge at which that enable was high.
- R5: With `par_fwd`=0 (generate), the outgoing parity is computed from the source latch data. The parity is chosen so that the nine-bit ones count is odd when `odd_sel`=1 and even when `odd_sel`=0.
- R6: With `par_fwd`=1 (forward), the outgoing parity bit is the source latch parity bit, passed on unchanged.
- R7: A flag (`a_err_n`, `b_err_n`) is 0 when its latch's data plus parity has an even ones count with `odd_sel`=1, or an odd ones count with `odd_sel`=0. Otherwise the flag is 1. There is no register on this path.
- R8: On the driven side, the latch input is the outgoing data and parity. That side's flag checks the outgoing word while its latch is transparent, and checks the held word while its latch is closed.
- R9: Reset clears both latches to zero data and zero parity. With `odd_sel`=0 both flags then read 1.
- R10: When the source latch is closed, the outgoing data, the generated parity and the source flag all come from the held word, not from the live bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch hold registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_drv_n | input | 1 | Active-low enable that drives the A side (B-to-A) |
| b_drv_n | input | 1 | Active-low enable that drives the B side (A-to-B) |
| par_fwd | input | 1 | 0 regenerates parity, 1 forwards the parity bit |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| a_le | input | 1 | A latch transparent when high |
| b_le | input | 1 | B latch transparent when high |
| a_in | input | DW | A bus data seen by the block |
| a_par_in | input | 1 | A bus parity seen by the block |
| a_out | output | DW | Data driven onto A |
| a_par_out | output | 1 | Parity driven onto A |
| a_oe | output | 1 | A side output enable |
| b_in | input | DW | B bus data seen by the block |
| b_par_in | input | 1 | B bus parity seen by the block |
| b_out | output | DW | Data driven onto B |
| b_par_out | output | 1 | Parity driven onto B |
| b_oe | output | 1 | B side output enable |
| a_err_n | output | 1 | A side parity error, active low |
| b_err_n | output | 1 | B side parity error, active low |

## Verification
The bench builds the block with its default data width of 8, so every 256-value data pattern and both parity polarities can be reached. A scoreboard model tracks its own copy of the two held words. This lets it reach hold-then-drive sequences where the live bus and the latched word differ. It also reaches the case where the closed destination latch flags a stale word while the outgoing word is correct. Directed steps cover idle, both directions in both parity modes, and bad incoming parity. A run of random stimulus then mixes latch enables, directions and parity settings.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_A2B  = 2'd1,
        DIR_B2A  = 2'd2
    } dir_e;

    // Both low is treated as idle so that the two sides never drive at once.
    function automatic dir_e decode_dir(input logic a_drv_n, input logic b_drv_n);
        if (!b_drv_n && a_drv_n) begin
            return DIR_A2B;
        end
        if (!a_drv_n && b_drv_n) begin
            return DIR_B2A;
        end
        return DIR_IDLE;
    endfunction

endpackage

// File: rtl/ptx_latch.sv
module ptx_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] held;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le) begin
            st_d.held = d;
        end
        q = le ? d : st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptx_parity.sv
module ptx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          odd_sel,
    output logic          gen_par,
    output logic          err_n
);

    logic data_x;
    logic word_x;

    always_comb begin
        data_x  = ^data;
        word_x  = data_x ^ par;
        gen_par = data_x ^ odd_sel;
        err_n   = ~(word_x ^ odd_sel);
    end

endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_drv_n,
    input  logic          b_drv_n,
    input  logic          par_fwd,
    input  logic          odd_sel,
    input  logic          a_le,
    input  logic          b_le,
    input  logic [DW-1:0] a_in,
    input  logic          a_par_in,
    output logic [DW-1:0] a_out,
    output logic          a_par_out,
    output logic          a_oe,
    input  logic [DW-1:0] b_in,
    input  logic          b_par_in,
    output logic [DW-1:0] b_out,
    output logic          b_par_out,
    output logic          b_oe,
    output logic          a_err_n,
    output logic          b_err_n
);
    import ptx_pkg::*;

    localparam int LW = DW + 1;

    dir_e          dir;
    logic [LW-1:0] a_lat_d, a_lat_q;
    logic [LW-1:0] b_lat_d, b_lat_q;
    logic          a_gen, b_gen;

    always_comb begin
        dir = decode_dir(a_drv_n, b_drv_n);
    end

    // B side output is built from the A latch.
    always_comb begin
        b_oe      = (dir == DIR_A2B);
        b_out     = b_oe ? a_lat_q[DW-1:0] : '0;
        b_par_out = b_oe ? (par_fwd ? a_lat_q[DW] : a_gen) : 1'b0;
    end

    // A side output is built from the B latch.
    always_comb begin
        a_oe      = (dir == DIR_B2A);
        a_out     = a_oe ? b_lat_q[DW-1:0] : '0;
        a_par_out = a_oe ? (par_fwd ? b_lat_q[DW] : b_gen) : 1'b0;
    end

    // A driven side takes back its own outgoing word.
    always_comb begin
        a_lat_d = a_oe ? {a_par_out, a_out} : {a_par_in, a_in};
        b_lat_d = b_oe ? {b_par_out, b_out} : {b_par_in, b_in};
    end

    ptx_latch #(.W(LW)) u_lat_a (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (a_le),
        .d     (a_lat_d),
        .q     (a_lat_q)
    );

    ptx_latch #(.W(LW)) u_lat_b (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (b_le),
        .d     (b_lat_d),
        .q     (b_lat_q)
    );

    ptx_parity #(.DW(DW)) u_par_a (
        .data    (a_lat_q[DW-1:0]),
        .par     (a_lat_q[DW]),
        .odd_sel (odd_sel),
        .gen_par (a_gen),
        .err_n   (a_err_n)
    );

    ptx_parity #(.DW(DW)) u_par_b (
        .data    (b_lat_q[DW-1:0]),
        .par     (b_lat_q[DW]),
        .odd_sel (odd_sel),
        .gen_par (b_gen),
        .err_n   (b_err_n)
    );

endmodule

// File: rtl/ptx_transceiver_chk.sv
module ptx_transceiver_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_drv_n,
    input logic          b_drv_n,
    input logic          par_fwd,
    input logic          odd_sel,
    input logic          a_le,
    input logic          b_le,
    input logic [DW-1:0] a_in,
    input logic          a_par_in,
    input logic [DW-1:0] a_out,
    input logic          a_par_out,
    input logic          a_oe,
    input logic [DW-1:0] b_in,
    input logic          b_par_in,
    input logic [DW-1:0] b_out,
    input logic          b_par_out,
    input logic          b_oe,
    input logic          a_err_n,
    input logic          b_err_n
);

    a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (a_drv_n == b_drv_n) |-> (!a_oe && !b_oe && b_out == '0 && a_out == '0));

    a_r3_a_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && a_le) |-> (b_out == a_in));

    a_r4_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_le && $past(!a_le) && b_oe && $past(b_oe)) |-> $stable(b_out));

    a_r5_gen_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !par_fwd) |-> ((^{b_out, b_par_out}) == odd_sel));

    a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && par_fwd && a_le) |-> (b_par_out == a_par_in));

    a_r7_src_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (a_le && !a_oe) |-> (a_err_n == ((^{a_in, a_par_in}) == odd_sel)));

    a_r8_dst_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && b_le && !par_fwd) |-> b_err_n);

endmodule

bind ptx_transceiver ptx_transceiver_chk #(.DW(DW)) u_chk (.*);

// File: tb/ptx_transceiver_tb.sv
`timescale 1ns/1ps
module ptx_transceiver_tb;

    localparam int DW = 8;

    typedef struct {
        logic [DW-1:0] a_out;
        logic          a_par;
        logic          a_oe;
        logic [DW-1:0] b_out;
        logic          b_par;
        logic          b_oe;
        logic          a_err_n;
        logic          b_err_n;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_drv_n = 1'b1, b_drv_n = 1'b1, par_fwd = 1'b0, odd_sel = 1'b0;
    logic          a_le = 1'b0, b_le = 1'b0;
    logic [DW-1:0] a_in = '0, b_in = '0;
    logic          a_par_in = 1'b0, b_par_in = 1'b0;
    logic [DW-1:0] a_out, b_out;
    logic          a_par_out, b_par_out, a_oe, b_oe, a_err_n, b_err_n;

    int   total = 0;
    int   bad = 0;
    exp_t q_exp[$];
    logic [DW:0] ha = '0, hb = '0;

    always #2 clk = ~clk;

    ptx_transceiver #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_drv_n(a_drv_n), .b_drv_n(b_drv_n),
        .par_fwd(par_fwd), .odd_sel(odd_sel), .a_le(a_le), .b_le(b_le),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out),
        .a_oe(a_oe), .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out),
        .b_par_out(b_par_out), .b_oe(b_oe), .a_err_n(a_err_n), .b_err_n(b_err_n)
    );

    function automatic logic flag_n(input logic [DW:0] w, input logic os);
        return ((^w) == os);
    endfunction

    task automatic check(input string req, input string what, input logic [DW:0] act, input logic [DW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare at the falling edge, away from the sampling edge.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            check(e.req, "a_oe", {8'h0, a_oe}, {8'h0, e.a_oe});
            check(e.req, "b_oe", {8'h0, b_oe}, {8'h0, e.b_oe});
            check(e.req, "a word", {a_par_out, a_out}, {e.a_par, e.a_out});
            check(e.req, "b word", {b_par_out, b_out}, {e.b_par, e.b_out});
            check(e.req, "a_err_n", {8'h0, a_err_n}, {8'h0, e.a_err_n});
            check(e.req, "b_err_n", {8'h0, b_err_n}, {8'h0, e.b_err_n});
        end
    end

    // Driver: apply one step, predict, push, then account for the clock edge.
    task automatic apply(input logic adn, input logic bdn, input logic fw, input logic os,
                         input logic lea, input logic leb,
                         input logic [DW:0] aw, input logic [DW:0] bw, input string req);
        exp_t e;
        logic a2b, b2a;
        logic [DW:0] qa, qb, da, db, outw;
        a_drv_n = adn; b_drv_n = bdn; par_fwd = fw; odd_sel = os;
        a_le = lea; b_le = leb;
        {a_par_in, a_in} = aw; {b_par_in, b_in} = bw;
        a2b = !bdn && adn;
        b2a = !adn && bdn;
        e.a_oe = b2a; e.b_oe = a2b;
        e.a_out = '0; e.a_par = 1'b0; e.b_out = '0; e.b_par = 1'b0;
        da = aw; db = bw;
        if (a2b) begin
            qa = lea ? da : ha;
            outw = {fw ? qa[DW] : ((^qa[DW-1:0]) ^ os), qa[DW-1:0]};
            e.b_out = outw[DW-1:0]; e.b_par = outw[DW];
            db = outw;
            qb = leb ? db : hb;
        end else if (b2a) begin
            qb = leb ? db : hb;
            outw = {fw ? qb[DW] : ((^qb[DW-1:0]) ^ os), qb[DW-1:0]};
            e.a_out = outw[DW-1:0]; e.a_par = outw[DW];
            da = outw;
            qa = lea ? da : ha;
        end else begin
            qa = lea ? da : ha;
            qb = leb ? db : hb;
        end
        e.a_err_n = flag_n(qa, os);
        e.b_err_n = flag_n(qb, os);
        e.req = req;
        q_exp.push_back(e);
        @(posedge clk);
        if (lea) ha = da;
        if (leb) hb = db;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 / R1: reset contents, idle, even parity
        apply(1, 1, 0, 0, 0, 0, 9'h1FF, 9'h0AA, "R9");
        apply(0, 0, 0, 0, 0, 0, 9'h000, 9'h000, "R1");
        // R2 R3 R5: A-to-B generate even, both latches transparent
        apply(1, 0, 0, 0, 1, 1, {1'b0, 8'h35}, 9'h000, "R5");
        // R5 R7: odd parity, incoming A parity now wrong
        apply(1, 0, 0, 1, 1, 1, {1'b0, 8'h35}, 9'h000, "R7");
        // R6 R8: forward a bad parity bit, both flags drop
        apply(1, 0, 1, 0, 1, 1, {1'b0, 8'h07}, 9'h000, "R6");
        // R2 R5: B-to-A generate odd
        apply(0, 1, 0, 1, 1, 1, 9'h000, {1'b1, 8'hC3}, "R2");
        // R3: capture in A, then R4 R10: hold while the bus changes
        apply(1, 1, 0, 0, 1, 0, {1'b0, 8'h81}, 9'h000, "R3");
        apply(1, 0, 0, 1, 0, 0, {1'b1, 8'hFF}, 9'h000, "R10");
        apply(1, 0, 1, 0, 0, 1, {1'b1, 8'h7E}, 9'h000, "R4");
        // R8: destination B closed, flag shows the held word
        apply(1, 1, 0, 0, 0, 1, 9'h000, {1'b0, 8'h01}, "R8");
        apply(1, 0, 0, 0, 1, 0, {1'b0, 8'h0F}, 9'h000, "R8");
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[0], r[1], r[2], r[3], r[4], r[5], 9'($urandom), 9'($urandom), "R7");
        end
        @(negedge clk);
        #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule